// File: doc/BRIEF.md
# Integer Data-Processing Unit with Condition Flags

This block is the arithmetic and logic stage of a 32-bit RISC core's data-processing path. It is purely combinational. A 4-bit operation code selects one of sixteen functions. The unit combines a first operand with a second operand that a shifter or immediate rotator upstream has already formed. It returns the result, a destination write-enable, and the next negative, zero, carry and overflow flag values.

The surrounding pipeline supplies four things. The first is the carry bit shifted out by the shifter or rotator. The second is an indication that the operand came from the immediate path. The third says whether that immediate path rotated by a nonzero amount. The last is the four current flags. A set-flags input decides whether the outputs carry new flags or simply pass the current ones through. All subtraction forms produce their carry and overflow the same way an adder would: the subtrahend is inverted and the add takes a carry-in.

Top module: `dp_alu`

## Requirements
- R1: Logical codes give these results, with `a` as the first operand and `b` as the second: 0x0 a AND b, 0x1 a XOR b, 0x8 a AND b, 0x9 a XOR b, 0xC a OR b, 0xD b, 0xE a AND NOT b, 0xF NOT b.
- R2: Add codes form x + y + k with x=a and y=b. Code 0x4 and code 0xB use k=0, and code 0x5 uses k equal to the current carry. The carry output is the carry out of bit 31. Overflow is set when x and y share a sign bit and the result's sign bit differs from it.
- R3: Subtract codes form x + y + k with x=a and y=NOT b. Code 0x2 and code 0xA use k=1, and code 0x6 uses k equal to the current carry, which gives a−b−(NOT C). Carry and overflow follow the rule of R2.
- R4: Reverse-subtract codes form x + y + k with x=b and y=NOT a. Code 0x3 uses k=1, and code 0x7 uses k equal to the current carry. Carry and overflow follow the rule of R2.
- R5: The destination write-enable is low for codes 0x8 to 0xB and high for every other code.
- R6: With set-flags high, the negative output equals result bit 31 and the zero output is high exactly when all 32 result bits are zero.
- R7: With set-flags high, a logical code whose operand did not come from the immediate path takes its carry output from the shifter carry input. For every logical code, the overflow output keeps the current overflow flag.
- R8: With set-flags high, a logical code whose operand came from the immediate path takes its carry output from the rotator carry input when the rotate was nonzero. When the rotate was zero, it keeps the current carry flag.
- R9: With set-flags low, all four flag outputs equal the current flag inputs, while the result and write-enable still follow R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted or rotated |
| shift_carry | input | 1 | Carry out of the shifter or rotator |
| imm_form | input | 1 | High when op_b came from the immediate path |
| rot_nonzero | input | 1 | High when the immediate rotate amount was nonzero |
| set_flags | input | 1 | High to update flags |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| wr_dest | output | 1 | Destination write-enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The bench sends uniformly random operands through all sixteen codes, with random flag, form and rotate inputs, so that every operand routing and carry-in choice is covered. Directed vectors add the arithmetic edges that random data rarely reaches. Signed overflow at 0x7FFFFFFF+1 tells the overflow rule apart from the carry rule. An unsigned wrap to zero and an equal-operand subtract check that carry and zero are set together. A borrow from zero checks that subtract carry means "no borrow". Carry-in cases on the with-carry codes separate k=C from a constant k. Immediate-form logical vectors with the rotate flag both high and low tell the rotator carry apart from the held carry.

// File: rtl/dp_alu_pkg.sv
// Shared opcode, flag-mode and control types for the data-processing unit.
// Assumes a 4-bit opcode space that is fully populated.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_OR  = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    // How carry and overflow are produced
    typedef enum logic [1:0] {
        FM_LOGIC = 2'd0,
        FM_ADD   = 2'd1,
        FM_SUB   = 2'd2,
        FM_RSB   = 2'd3
    } flag_mode_e;

    // Function of the logic unit
    typedef enum logic [2:0] {
        LG_AND   = 3'd0,
        LG_XOR   = 3'd1,
        LG_OR    = 3'd2,
        LG_PASS  = 3'd3,
        LG_CLEAR = 3'd4,
        LG_INV   = 3'd5
    } logic_fn_e;

    typedef struct packed {
        flag_mode_e mode;
        logic_fn_e  fn;
        logic       use_carry;   // carry-in is the current C flag
        logic       wr_dest;
    } alu_ctl_t;

endpackage

// File: rtl/dp_alu_decode.sv
// Opcode decoder: maps the 4-bit opcode to a flag mode, a logic function,
// the carry-in source and the destination write-enable.
// Assumes nothing about the operands; it is purely a function of opcode.
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode,
    output alu_ctl_t   ctl
);

    // Translate the opcode into control fields
    always_comb begin
        ctl = '{mode: FM_LOGIC, fn: LG_AND, use_carry: 1'b0, wr_dest: 1'b1};
        case (alu_op_e'(opcode))
            OP_AND: ctl.fn = LG_AND;
            OP_XOR: ctl.fn = LG_XOR;
            OP_SUB: ctl.mode = FM_SUB;
            OP_RSB: ctl.mode = FM_RSB;
            OP_ADD: ctl.mode = FM_ADD;
            OP_ADC: begin ctl.mode = FM_ADD; ctl.use_carry = 1'b1; end
            OP_SBC: begin ctl.mode = FM_SUB; ctl.use_carry = 1'b1; end
            OP_RSC: begin ctl.mode = FM_RSB; ctl.use_carry = 1'b1; end
            OP_TST: begin ctl.fn = LG_AND; ctl.wr_dest = 1'b0; end
            OP_TEQ: begin ctl.fn = LG_XOR; ctl.wr_dest = 1'b0; end
            OP_CMP: begin ctl.mode = FM_SUB; ctl.wr_dest = 1'b0; end
            OP_CMN: begin ctl.mode = FM_ADD; ctl.wr_dest = 1'b0; end
            OP_OR:  ctl.fn = LG_OR;
            OP_MOV: ctl.fn = LG_PASS;
            OP_BIC: ctl.fn = LG_CLEAR;
            OP_MVN: ctl.fn = LG_INV;
            default: ctl.fn = LG_AND;
        endcase
    end

    // Guard: the compare and test group never writes the destination
    always_comb begin
        if (opcode[3:2] == 2'b10)
            AST_CMP_NO_WRITE: assert (!ctl.wr_dest); // R5
    end

endmodule

// File: rtl/dp_alu_adder.sv
// Ripple-free behavioural adder: sum = x + y + cin, with the carry out of
// the top bit and the two's-complement overflow of the same add.
// Assumes the caller has already inverted any subtrahend.
module dp_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide;

    // Extended-width addition with carry-in
    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end

    // Guard: signed overflow only happens when both addends share a sign
    always_comb begin
        if (ovf)
            AST_OVF_SAME_SIGN: assert (x[MSB] == y[MSB]); // R2
    end

endmodule

// File: rtl/dp_alu_logic.sv
// Bitwise logic unit. Each output bit depends only on the matching input
// bits, so the function is built bit by bit in a generate loop.
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Per-bit function select
        always_comb begin
            case (fn)
                LG_AND:   y[i] = a[i] & b[i];
                LG_XOR:   y[i] = a[i] ^ b[i];
                LG_OR:    y[i] = a[i] | b[i];
                LG_PASS:  y[i] = b[i];
                LG_CLEAR: y[i] = a[i] & ~b[i];
                LG_INV:   y[i] = ~b[i];
                default:  y[i] = a[i] & b[i];
            endcase
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Data-processing unit top. It routes the operands into the adder
// according to the flag mode, selects the adder or logic result, and forms
// the next N, Z, C and V flags. Combinational; assumes op_b and
// shift_carry come from a shifter or rotator upstream.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_carry,
    input  logic             imm_form,
    input  logic             rot_nonzero,
    input  logic             set_flags,
    input  logic             n_in,
    input  logic             z_in,
    input  logic             c_in,
    input  logic             v_in,
    output logic [WIDTH-1:0] result,
    output logic             wr_dest,
    output logic             n_out,
    output logic             z_out,
    output logic             c_out,
    output logic             v_out
);

    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] add_x, add_y, add_sum, lg_res;
    logic             add_cin, add_cout, add_ovf;
    logic             is_arith, lg_carry;

    dp_alu_decode u_decode (
        .opcode (opcode),
        .ctl    (ctl)
    );

    // Operand routing and carry-in for the add, subtract and reverse forms
    always_comb begin
        case (ctl.mode)
            FM_SUB:  begin add_x = op_a; add_y = ~op_b; end
            FM_RSB:  begin add_x = op_b; add_y = ~op_a; end
            default: begin add_x = op_a; add_y = op_b;  end
        endcase
        if (ctl.use_carry)
            add_cin = c_in;
        else
            add_cin = (ctl.mode == FM_SUB) || (ctl.mode == FM_RSB);
    end

    dp_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .fn (ctl.fn),
        .y  (lg_res)
    );

    // Carry source for logical codes: rotator carry unless an unrotated immediate
    always_comb begin
        lg_carry = (imm_form && !rot_nonzero) ? c_in : shift_carry;
    end

    // Result select and flag formation
    always_comb begin
        is_arith = (ctl.mode != FM_LOGIC);
        result   = is_arith ? add_sum : lg_res;
        wr_dest  = ctl.wr_dest;
        if (set_flags) begin
            n_out = result[MSB];
            z_out = (result == '0);
            c_out = is_arith ? add_cout : lg_carry;
            v_out = is_arith ? add_ovf  : v_in;
        end else begin
            n_out = n_in;
            z_out = z_in;
            c_out = c_in;
            v_out = v_in;
        end
    end

    // Guards on the flag outputs at the ports
    always_comb begin
        if (!set_flags)
            AST_FLAGS_HELD: assert ({n_out, z_out, c_out, v_out} == {n_in, z_in, c_in, v_in}); // R9
        if (set_flags)
            AST_ZERO_MATCH: assert (z_out == (result == '0)); // R6
        if (set_flags && opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
            AST_LOGIC_V_KEPT: assert (v_out == v_in); // R7
        if (set_flags && imm_form && !rot_nonzero && opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
            AST_IMM_C_KEPT: assert (c_out == c_in); // R8
    end

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        shift_carry = 1'b0, imm_form = 1'b0, rot_nonzero = 1'b0;
    logic        set_flags = 1'b0;
    logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic [31:0] result;
    logic        wr_dest, n_out, z_out, c_out, v_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dp_alu u_dut (
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
        .imm_form(imm_form), .rot_nonzero(rot_nonzero), .set_flags(set_flags),
        .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
        .result(result), .wr_dest(wr_dest), .n_out(n_out), .z_out(z_out),
        .c_out(c_out), .v_out(v_out)
    );

    // Expected {result, wr, n, z, c, v} from the requirements
    function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a, b,
                                          input logic sc, im, rot, sf, n, z, c, v);
        logic [32:0] t;
        logic [31:0] r, x, y;
        logic wr, cc, vv, ar, ci;
        ar = 1'b0; wr = 1'b1; x = '0; y = '0; ci = 1'b0; r = '0;
        case (op)
            4'h0: r = a & b;
            4'h1: r = a ^ b;
            4'h8: begin r = a & b; wr = 1'b0; end
            4'h9: begin r = a ^ b; wr = 1'b0; end
            4'hC: r = a | b;
            4'hD: r = b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            4'h2, 4'h6, 4'hA: begin x = a; y = ~b; ci = (op == 4'h6) ? c : 1'b1; ar = 1'b1; end
            4'h3, 4'h7:       begin x = b; y = ~a; ci = (op == 4'h7) ? c : 1'b1; ar = 1'b1; end
            default:          begin x = a; y = b;  ci = (op == 4'h5) ? c : 1'b0; ar = 1'b1; end
        endcase
        if (op == 4'hA || op == 4'hB) wr = 1'b0;
        if (ar) begin
            t  = {1'b0, x} + {1'b0, y} + {32'd0, ci};
            r  = t[31:0];
            cc = t[32];
            vv = (x[31] == y[31]) && (r[31] != x[31]);
        end else begin
            cc = (im && !rot) ? c : sc;
            vv = v;
        end
        if (sf) return {r, wr, r[31], (r == 32'd0), cc, vv};
        return {r, wr, n, z, c, v};
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        if (op inside {4'h2, 4'h6, 4'hA}) return "R3";
        if (op inside {4'h3, 4'h7})       return "R4";
        if (op inside {4'h4, 4'h5, 4'hB}) return "R2";
        return "R1";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s op=%h a=%h b=%h actual=%h expected=%h",
                     tag, what, opcode, op_a, op_b, act, exp);
        end
    endtask

    // Apply one vector, wait away from the clock edge, compare every output
    task automatic run(input logic [3:0] op, input logic [31:0] a, b,
                       input logic sc, im, rot, sf, n, z, c, v);
        logic [36:0] e;
        string ft;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; shift_carry = sc; imm_form = im;
        rot_nonzero = rot; set_flags = sf; n_in = n; z_in = z; c_in = c; v_in = v;
        #1;
        e = model(op, a, b, sc, im, rot, sf, n, z, c, v);
        check(res_tag(op), "result", result, e[36:5]);
        check("R5", "wr_dest", {31'd0, wr_dest}, {31'd0, e[4]});
        check(sf ? "R6" : "R9", "nz", {30'd0, n_out, z_out}, {30'd0, e[3:2]});
        if (!sf)                      ft = "R9";
        else if (res_tag(op) != "R1") ft = res_tag(op);
        else if (im)                  ft = "R8";
        else                          ft = "R7";
        check(ft, "cv", {30'd0, c_out, v_out}, {30'd0, e[1:0]});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state vector: all inputs zero -> AND of zeros, write on, flags held
        #1;
        check("R9", "idle result", result, 32'd0);
        check("R5", "idle wr", {31'd0, wr_dest}, 32'd1);
        check("R9", "idle flags", {28'd0, n_out, z_out, c_out, v_out}, 32'd0);

        // R2 corners: signed overflow, unsigned wrap, add with carry
        run(4'h4, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h4, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h5, 32'hFFFF_FFFF, 32'd0, 0, 0, 0, 1, 0, 0, 1, 0);
        run(4'hB, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1, 0, 0, 0, 0);
        // R3 corners: equal operands, borrow from zero, signed overflow, carry-in
        run(4'h2, 32'd5, 32'd5, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h2, 32'd0, 32'd1, 0, 0, 0, 1, 0, 0, 1, 0);
        run(4'hA, 32'h8000_0000, 32'd1, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h6, 32'd10, 32'd3, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h6, 32'd10, 32'd3, 0, 0, 0, 1, 0, 0, 1, 0);
        // R4 corners
        run(4'h3, 32'd3, 32'd10, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h7, 32'd3, 32'd10, 0, 0, 0, 1, 0, 0, 0, 0);
        run(4'h3, 32'd1, 32'd0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R7 and R8: carry sources for logical codes
        run(4'hD, 32'd0, 32'd0, 1, 0, 0, 1, 0, 0, 0, 1);
        run(4'hD, 32'd0, 32'd7, 1, 1, 0, 1, 0, 0, 0, 1);
        run(4'hF, 32'd0, 32'd7, 1, 1, 1, 1, 0, 0, 0, 0);
        run(4'h8, 32'hF0F0_0000, 32'h0F0F_FFFF, 0, 1, 0, 1, 0, 0, 1, 0);
        // R9: flags held with set-flags low, result still computed
        run(4'h4, 32'h7FFF_FFFF, 32'd1, 1, 0, 0, 0, 1, 1, 0, 1);
        run(4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 1, 1, 1, 0, 0, 1, 1, 0);

        // Random sweep over every code
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] bits;
            bits = 10'($urandom);
            run(4'($urandom), $urandom, $urandom, bits[0], bits[1], bits[2],
                bits[3] | bits[4], bits[5], bits[6], bits[7], bits[8]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule